// File: doc/BRIEF.md
# Async Transaction Slot Manager

This block keeps the two pending bus transactions of an asynchronous list-walking DMA engine. The fetch side offers one request at a time: a queue-head identifier, a packet length in bytes and a ping flag. The block takes the request only if a slot is free, no slot already holds the same queue head, and the block is not halted. Held entries go to the wire one at a time, oldest first.

Before each launch the block compares the cost of the packet with the time left in the current microframe. A packet that does not fit stops port activity until the next microframe begins. The entry stays in its slot and launches at the start of the next microframe without being fetched again. A slot is released when the engine reports that the final results of the running transaction have been posted to memory. A host error flushes every entry and halts the block until reset. A ping entry goes to the wire with no data fetch.

Top module: `async_slot_mgr`

## Requirements
- R1: After reset both slots are empty, `halted`, `port_frozen`, `xact_start`, `late_miss` and `slot_free` are low, and a valid request is accepted in the same cycle (`req_accept` high).
- R2: `req_accept` is high exactly when `req_valid` is high, at least one slot is free, no held entry has the same queue head, `host_err` is low and the block is not halted. With both slots held, a third request is refused.
- R3: A request whose queue head matches a held entry is refused even when the other slot is free. This includes the cycle in which that entry is being released. The same queue head is accepted in the cycle after the release.
- R4: Held entries launch in arrival order. During the launch cycle, `xact_qh` and `xact_len` show the launched entry.
- R5: At most one transaction is in flight. No launch occurs from the cycle after a launch until the cycle after `post_done`.
- R6: `post_done` while a transaction is in flight frees that slot, and `slot_free` is high in that same cycle. `post_done` with nothing in flight has no effect: `slot_free` stays low.
- R7: Packet cost is len*BYTE_T+OVH, or OVH alone for a ping. The time available in a cycle is UF_TICKS in a `uf_start` cycle and UF_TICKS-k in the k-th cycle after it, with a floor of 0. Before the first `uf_start` it is 0. The oldest idle entry launches (`xact_start`) if its cost is no more than the available time. Otherwise `late_miss` pulses.
- R8: After a `late_miss`, `port_frozen` is high from the next cycle until the next `uf_start`. No launch occurs while frozen, except in a `uf_start` cycle.
- R9: A deferred entry is checked again in the next `uf_start` cycle, with the same queue head and length and no new request. It launches if its cost is no more than UF_TICKS and misses again otherwise.
- R10: `xact_fetch` equals `xact_start` for a non-ping entry and stays low for a ping entry.
- R11: `host_err` empties both slots, refuses any request in that cycle, and raises `slot_free` in that cycle if any slot was held. From the next cycle `halted` stays high until reset, with no accept and no launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uf_start | input | 1 | Microframe-start pulse; reloads the time budget |
| req_valid | input | 1 | Fetched request offered |
| req_qh | input | QH_W | Queue-head identifier of the request |
| req_len | input | LEN_W | Packet length in bytes |
| req_ping | input | 1 | Request is a ping (no data) |
| req_accept | output | 1 | Request taken into a slot this cycle |
| post_done | input | 1 | Final results of the in-flight transaction posted |
| host_err | input | 1 | Host error: flush and halt |
| xact_start | output | 1 | Oldest entry launched this cycle |
| xact_qh | output | QH_W | Queue head of the oldest entry |
| xact_len | output | LEN_W | Length of the oldest entry |
| xact_fetch | output | 1 | Launch needs a data fetch |
| late_miss | output | 1 | Late-start check failed this cycle |
| port_frozen | output | 1 | Port idle until next microframe |
| slot_free | output | 1 | A slot became available this cycle |
| halted | output | 1 | Halted after host error |

## Verification
The collision that matters most is a release and a new fetch in the same cycle. The bench drives `post_done` together with a request that carries the queue head of the entry being released. It expects a refusal, then acceptance one cycle later. The second collision is a late-start miss followed by the next microframe. The bench sweeps the packet length against several offsets into the microframe and computes the expected launch or miss from the cost formula. For every miss it then pulses `uf_start` and expects the deferred entry to launch or miss again according to its cost against the full budget.

// File: rtl/slot_pkg.sv
package slot_pkg;
  // Wire-time cost of one packet: payload time plus fixed overhead.
  function automatic int unsigned pkt_cost(input int unsigned len, input bit ping,
                                           input int unsigned byte_t, input int unsigned ovh);
    return ping ? ovh : (len * byte_t + ovh);
  endfunction
endpackage

// File: rtl/slot_store.sv
module slot_store #(
  parameter int QH_W  = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [QH_W-1:0]  wr_qh,
  input  logic [LEN_W-1:0] wr_len,
  input  logic             wr_ping,
  input  logic             pop,
  input  logic             flush,
  input  logic [QH_W-1:0]  match_qh,
  output logic [1:0]       vld,
  output logic             full,
  output logic             dup,
  output logic [QH_W-1:0]  head_qh,
  output logic [LEN_W-1:0] head_len,
  output logic             head_ping,
  output logic             head_vld,
  output logic [QH_W-1:0]  qh_a,
  output logic [QH_W-1:0]  qh_b
);
  localparam int NSLOT = 2;

  logic             vld_q  [NSLOT];
  logic [QH_W-1:0]  qh_q   [NSLOT];
  logic [LEN_W-1:0] len_q  [NSLOT];
  logic             ping_q [NSLOT];
  logic [NSLOT-1:0] hit;
  logic             old_q;
  logic             free_idx;

  assign free_idx = vld_q[0];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic set_g, clr_g;
    assign set_g  = wr_en && (free_idx == 1'(g));
    assign clr_g  = flush || (pop && (old_q == 1'(g)));
    assign hit[g] = vld_q[g] && (qh_q[g] == match_qh);
    assign vld[g] = vld_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g]  <= 1'b0;
        qh_q[g]   <= '0;
        len_q[g]  <= '0;
        ping_q[g] <= 1'b0;
      end else if (clr_g) begin
        vld_q[g]  <= 1'b0;
      end else if (set_g) begin
        vld_q[g]  <= 1'b1;
        qh_q[g]   <= wr_qh;
        len_q[g]  <= wr_len;
        ping_q[g] <= wr_ping;
      end
    end
  end

  // Arrival order: old_q points at the oldest held entry.
  always_ff @(posedge clk) begin
    if (!rst_n || flush)               old_q <= 1'b0;
    else if (pop)                      old_q <= ~old_q;
    else if (vld == 2'b00 && wr_en)    old_q <= free_idx;
  end

  assign full      = vld_q[0] && vld_q[1];
  assign dup       = |hit;
  assign head_vld  = vld_q[old_q];
  assign head_qh   = qh_q[old_q];
  assign head_len  = len_q[old_q];
  assign head_ping = ping_q[old_q];
  assign qh_a      = qh_q[0];
  assign qh_b      = qh_q[1];
endmodule

// File: rtl/late_check.sv
module late_check
  import slot_pkg::*;
#(
  parameter int UF_TICKS = 7500,
  parameter int LEN_W    = 8,
  parameter int BYTE_T   = 8,
  parameter int OVH      = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uf_start,
  input  logic             cand,
  input  logic [LEN_W-1:0] len,
  input  logic             ping,
  output logic             go,
  output logic             miss,
  output logic             frozen
);
  localparam int TW = $clog2(UF_TICKS + 1);

  logic [TW-1:0] t_left_q;
  logic [TW-1:0] avail;
  logic          elig;
  logic          fits;
  logic          frozen_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                t_left_q <= '0;
    else if (uf_start)         t_left_q <= TW'(UF_TICKS - 1);
    else if (t_left_q != '0)   t_left_q <= t_left_q - 1'b1;
  end

  assign avail = uf_start ? TW'(UF_TICKS) : t_left_q;
  assign fits  = pkt_cost(32'(len), ping, BYTE_T, OVH) <= 32'(avail);
  assign elig  = cand && (!frozen_q || uf_start);
  assign go    = elig && fits;
  assign miss  = elig && !fits;

  always_ff @(posedge clk) begin
    if (!rst_n)        frozen_q <= 1'b0;
    else if (uf_start) frozen_q <= miss;
    else if (miss)     frozen_q <= 1'b1;
  end

  assign frozen = frozen_q;
endmodule

// File: rtl/async_slot_mgr.sv
module async_slot_mgr #(
  parameter int QH_W     = 4,
  parameter int LEN_W    = 8,
  parameter int UF_TICKS = 7500,
  parameter int BYTE_T   = 8,
  parameter int OVH      = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uf_start,
  input  logic             req_valid,
  input  logic [QH_W-1:0]  req_qh,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_ping,
  output logic             req_accept,
  input  logic             post_done,
  input  logic             host_err,
  output logic             xact_start,
  output logic [QH_W-1:0]  xact_qh,
  output logic [LEN_W-1:0] xact_len,
  output logic             xact_fetch,
  output logic             late_miss,
  output logic             port_frozen,
  output logic             slot_free,
  halted
);
  logic [1:0]       vld;
  logic             full, dup, head_vld, head_ping;
  logic [QH_W-1:0]  head_qh, qh_a, qh_b;
  logic [LEN_W-1:0] head_len;
  logic             run_q, halt_q;
  logic             pop, cand, go, miss, frozen;

  assign req_accept = req_valid && !halt_q && !host_err && !full && !dup;
  assign pop        = post_done && run_q && !host_err;
  assign cand       = head_vld && !run_q && !halt_q && !host_err;

  slot_store #(.QH_W(QH_W), .LEN_W(LEN_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(req_accept), .wr_qh(req_qh), .wr_len(req_len), .wr_ping(req_ping),
    .pop(pop), .flush(host_err), .match_qh(req_qh),
    .vld(vld), .full(full), .dup(dup),
    .head_qh(head_qh), .head_len(head_len), .head_ping(head_ping), .head_vld(head_vld),
    .qh_a(qh_a), .qh_b(qh_b)
  );

  late_check #(.UF_TICKS(UF_TICKS), .LEN_W(LEN_W), .BYTE_T(BYTE_T), .OVH(OVH)) u_late (
    .clk(clk), .rst_n(rst_n), .uf_start(uf_start),
    .cand(cand), .len(head_len), .ping(head_ping),
    .go(go), .miss(miss), .frozen(frozen)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || host_err) run_q <= 1'b0;
    else if (pop)           run_q <= 1'b0;
    else if (go)            run_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        halt_q <= 1'b0;
    else if (host_err) halt_q <= 1'b1;
  end

  assign xact_start  = go;
  assign xact_qh     = head_qh;
  assign xact_len    = head_len;
  assign xact_fetch  = go && !head_ping;
  assign late_miss   = miss;
  assign port_frozen = frozen;
  assign slot_free   = pop || (host_err && !halt_q && (vld != 2'b00));
  assign halted      = halt_q;
endmodule

// File: rtl/slot_mgr_chk.sv
module slot_mgr_chk #(
  parameter int QH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            uf_start,
  input logic            req_accept,
  input logic            post_done,
  input logic            host_err,
  input logic            xact_start,
  input logic            late_miss,
  input logic            port_frozen,
  input logic            slot_free,
  input logic            halted,
  input logic            run_q,
  input logic [1:0]      vld,
  input logic [QH_W-1:0] qh_a,
  input logic [QH_W-1:0] qh_b
);
  a_r2_full_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (vld == 2'b11) |-> !req_accept);
  a_r3_no_dup_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (vld == 2'b11) |-> (qh_a != qh_b));
  a_r5_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !xact_start);
  a_r6_free_source: assert property (@(posedge clk) disable iff (!rst_n)
    slot_free |-> (post_done || host_err));
  a_r7_start_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(xact_start && late_miss));
  a_r8_miss_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    late_miss |=> port_frozen);
  a_r8_frozen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (port_frozen && !uf_start) |-> !xact_start);
  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  a_r11_halted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!req_accept && !xact_start));
endmodule

bind async_slot_mgr slot_mgr_chk #(.QH_W(QH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .uf_start(uf_start), .req_accept(req_accept),
  .post_done(post_done), .host_err(host_err), .xact_start(xact_start),
  .late_miss(late_miss), .port_frozen(port_frozen), .slot_free(slot_free),
  .halted(halted), .run_q(run_q), .vld(vld), .qh_a(qh_a), .qh_b(qh_b)
);

// File: tb/tb_async_slot_mgr.sv
`timescale 1ns/1ps
module tb_async_slot_mgr;
  localparam int QH_W = 4, LEN_W = 8, UF = 200, BT = 1, OV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic uf_start = 0, req_valid = 0, req_ping = 0, post_done = 0, host_err = 0;
  logic [QH_W-1:0] req_qh = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_accept, xact_start, xact_fetch, late_miss, port_frozen, slot_free, halted;
  logic [QH_W-1:0] xact_qh;
  logic [LEN_W-1:0] xact_len;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  async_slot_mgr #(.QH_W(QH_W), .LEN_W(LEN_W), .UF_TICKS(UF), .BYTE_T(BT), .OVH(OV)) dut (
    .clk(clk), .rst_n(rst_n), .uf_start(uf_start), .req_valid(req_valid),
    .req_qh(req_qh), .req_len(req_len), .req_ping(req_ping), .req_accept(req_accept),
    .post_done(post_done), .host_err(host_err), .xact_start(xact_start),
    .xact_qh(xact_qh), .xact_len(xact_len), .xact_fetch(xact_fetch),
    .late_miss(late_miss), .port_frozen(port_frozen), .slot_free(slot_free),
    .halted(halted));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle's inputs at the falling edge; outputs settle 1 ns later.
  task automatic drive(input bit uf, input bit rv, input int qh, input int len,
                       input bit ping, input bit done, input bit err);
    @(negedge clk);
    uf_start = uf; req_valid = rv; req_qh = QH_W'(qh); req_len = LEN_W'(len);
    req_ping = ping; post_done = done; host_err = err;
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; uf_start = 0; req_valid = 0; post_done = 0; host_err = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  function automatic int cost(input int len, input bit ping);
    return ping ? OV : len * BT + OV;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    idle();
    chk("R1 xact_start", xact_start, 0);
    chk("R1 late_miss", late_miss, 0);
    chk("R1 slot_free", slot_free, 0);
    chk("R1 halted", halted, 0);
    chk("R1 port_frozen", port_frozen, 0);
    drive(0, 1, 1, 3, 0, 0, 0);
    chk("R1 first accept", req_accept, 1);

    // R2..R6: ordering, duplicates, single flight, release
    do_reset();
    drive(1, 0, 0, 0, 0, 0, 0);                 // microframe begins
    drive(0, 1, 1, 10, 0, 0, 0);
    chk("R2 accept qh1", req_accept, 1);
    drive(0, 1, 1, 10, 0, 0, 0);                // avail 198, cost 14
    chk("R4 start qh1", xact_start, 1);
    chk("R4 qh of launch", xact_qh, 1);
    chk("R4 len of launch", xact_len, 10);
    chk("R10 data fetch", xact_fetch, 1);
    chk("R3 dup refused", req_accept, 0);
    drive(0, 1, 2, 20, 0, 0, 0);
    chk("R2 accept qh2", req_accept, 1);
    chk("R5 no second launch", xact_start, 0);
    drive(0, 1, 3, 5, 0, 0, 0);
    chk("R2 full refuses", req_accept, 0);
    chk("R5 still single", xact_start, 0);
    drive(0, 1, 1, 7, 0, 1, 0);                 // release qh1, same-cycle refetch
    chk("R6 slot_free", slot_free, 1);
    chk("R3 refused during release", req_accept, 0);
    drive(0, 1, 1, 7, 0, 0, 0);
    chk("R3 accepted after release", req_accept, 1);
    chk("R4 qh2 next", xact_start, 1);
    chk("R4 qh2 id", xact_qh, 2);
    drive(0, 0, 0, 0, 0, 1, 0);
    chk("R6 slot_free qh2", slot_free, 1);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R4 qh1 third", xact_start, 1);
    chk("R4 qh1 id", xact_qh, 1);
    chk("R4 qh1 len", xact_len, 7);
    drive(0, 0, 0, 0, 0, 1, 0);
    chk("R6 release last", slot_free, 1);
    drive(0, 0, 0, 0, 0, 1, 0);
    chk("R6 idle done ignored", slot_free, 0);
    chk("R6 idle no start", xact_start, 0);

    // R7..R10: late-start sweep over length and offset into microframe
    for (int ki = 0; ki < 3; ki++) begin
      for (int len = 0; len < 256; len += 3) begin
        int k, av;
        bit fit;
        k = (ki == 0) ? 0 : (ki == 1) ? 50 : 150;
        do_reset();
        drive(1, 0, 0, 0, 0, 0, 0);
        for (int w = 0; w < k; w++) idle();
        drive(0, 1, 9, len, 0, 0, 0);
        idle();
        av = UF - (k + 2);
        fit = cost(len, 0) <= av;
        chk("R7 launch vs budget", xact_start, int'(fit));
        chk("R7 miss vs budget", late_miss, int'(!fit));
        if (fit) chk("R10 fetch on data", xact_fetch, 1);
        if (!fit) begin
          idle();
          chk("R8 frozen", port_frozen, 1);
          chk("R8 no launch frozen", xact_start + late_miss, 0);
          drive(1, 0, 0, 0, 0, 0, 0);
          chk("R9 relaunch", xact_start, int'(cost(len, 0) <= UF));
          chk("R9 remiss", late_miss, int'(cost(len, 0) > UF));
          chk("R9 same len", xact_len, len);
          chk("R9 same qh", xact_qh, 9);
        end
      end
    end

    // R10: ping costs overhead only, never fetches data
    do_reset();
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(0, 1, 4, 250, 1, 0, 0);
    idle();
    chk("R10 ping launches", xact_start, 1);
    chk("R10 ping no fetch", xact_fetch, 0);
    chk("R7 ping cost", late_miss, 0);

    // R11: host error flush and halt
    do_reset();
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(0, 1, 5, 1, 0, 0, 0);
    drive(0, 1, 6, 1, 0, 0, 0);
    drive(0, 1, 7, 1, 0, 0, 1);
    chk("R11 refuse on error", req_accept, 0);
    chk("R11 slot_free on flush", slot_free, 1);
    drive(0, 1, 7, 1, 0, 0, 0);
    chk("R11 halted", halted, 1);
    chk("R11 no accept halted", req_accept, 0);
    drive(1, 0, 0, 0, 0, 0, 0);
    chk("R11 no launch halted", xact_start, 0);
    drive(0, 0, 0, 0, 0, 1, 0);
    chk("R11 no free halted", slot_free, 0);
    chk("R11 still halted", halted, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule